// File: doc/BRIEF.md
# Vectored Interrupt Entry Sequencer

This block decides when a 24-bit processor leaves its instruction stream. It sends the program counter to the start address after reset, and to a fixed vector when an interrupt is accepted. Two active-low hardware request lines pass through a synchroniser. They are then combined with software request bits held in the processor status register. A request is accepted only when the core signals that an instruction has just completed. When a request is accepted, the block emits a one-cycle take pulse together with a program-counter load pulse and the vector address.

The block also owns the 8-bit processor status register. The ALU updates the three condition flags through a flag-write port. A status-write port, used by the status-register write instruction, replaces the whole register. The block does not save the return address and does not run the service routine.

Status register layout: bit 0 zero flag, bit 1 carry flag, bit 2 sign flag, bit 3 interrupt enable, bits 7:4 software request bits.

Top module: `intEntrySeq`

## Requirements
- R1: In the first cycle after reset is released, `pcLoad` is high for one cycle with `pcVector` = 0x000000 and `takeIrq` low.
- R2: While `rst` is high, `psrOut` reads 0x00 (interrupt enable bit 3 clear), and `pcLoad` and `takeIrq` are low.
- R3: An interrupt is accepted only at a clock edge where `instrDone` is 1. The `takeIrq` and `pcLoad` pulses appear in the cycle after that edge.
- R4: An accepted request from `irqN[0]` (low) gives `pcVector` = 0x000002. An accepted request from `irqN[1]` gives 0x000004.
- R5: When both `irqN` lines are low, the vector is 0x000004.
- R6: Any non-zero value in status bits 7:4 raises a request that vectors to 0x000002, provided bit 3 is set. A low `irqN[1]` takes priority over it.
- R7: Accepting an interrupt clears status bit 3. No further interrupt is accepted until software sets bit 3 again.
- R8: Accepting an interrupt leaves status bits 7:4 unchanged. They change only through a status write.
- R9: A level on `irqN` must pass two synchroniser flops. A line driven low before edge 1, with `instrDone` held high, produces its `pcLoad` after edge 3 and not earlier.
- R10: While bit 3 is clear, low `irqN` lines and set software bits are ignored. No `pcLoad` or `takeIrq` occurs.
- R11: `flagWe` writes `flagIn` into status bits 2:0 only. `psrWe` writes all 8 bits. When both are high, `psrWe` wins.
- R12: The acceptance decision uses the status value held before a same-edge status write. When a write and an acceptance share an edge, the written value is stored with bit 3 then forced to 0.
- R13: `takeIrq` never stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irqN | input | 2 | Hardware interrupt requests, active low, asynchronous |
| instrDone | input | 1 | High in the cycle an instruction completes |
| flagWe | input | 1 | ALU flag write strobe |
| flagIn | input | 3 | New flag values {sign, carry, zero} |
| psrWe | input | 1 | Status register write strobe |
| psrIn | input | 8 | Value for the status register write |
| psrOut | output | 8 | Current status register |
| pcLoad | output | 1 | Program counter load pulse |
| takeIrq | output | 1 | Interrupt accepted pulse |
| pcVector | output | 24 | Address to load into the program counter |

## Verification
The assertions check the following properties on every cycle:
- every take pulse lands on an instruction boundary, lasts one cycle and finds the enable bit cleared;
- a take never occurs without prior enable;
- the software request bits survive a take;
- the vector matches the line that won priority;
- a non-interrupt load always carries the boot address.

Only the directed scenarios can show three further properties. The first is the exact synchroniser latency. The second is that an interrupt stays blocked while the enable bit is clear. The third is the ordering between a same-edge status write and an acceptance, including whether a freshly written software request is taken on that edge or on the next.

// File: rtl/intEntryPkg.sv
package intEntryPkg;

  typedef enum logic [1:0] {
    VSEL_BOOT = 2'd0,
    VSEL_LOW  = 2'd1,
    VSEL_HIGH = 2'd2
  } vecSel_e;

  typedef struct packed {
    logic    load;
    logic    take;
    vecSel_e sel;
  } ctrlStrobe_t;

endpackage

// File: rtl/intEntryCtrl.sv
module intEntryCtrl
  import intEntryPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        instrDone,
  input  logic [1:0]  irqActive,
  input  logic        intEnable,
  input  logic        swAny,
  output ctrlStrobe_t strobe
);

  logic bootPending;
  logic lowReq;
  logic anyReq;
  logic takeNow;

  always_ff @(posedge clk) begin
    if (rst) bootPending <= 1'b1;
    else     bootPending <= 1'b0;
  end

  always_comb begin
    lowReq  = irqActive[0] | swAny;
    anyReq  = irqActive[1] | lowReq;
    takeNow = !bootPending && instrDone && intEnable && anyReq;

    strobe.load = bootPending | takeNow;
    strobe.take = takeNow;
    if (bootPending)       strobe.sel = VSEL_BOOT;
    else if (irqActive[1]) strobe.sel = VSEL_HIGH;
    else                   strobe.sel = VSEL_LOW;
  end

  // R1: the boot request lives for exactly one cycle after reset
  a_r1_boot_once: assert property (@(posedge clk) disable iff (rst)
    bootPending |=> !bootPending);

endmodule

// File: rtl/intEntryPath.sv
module intEntryPath
  import intEntryPkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int SYNC_STAGES = 2,
  parameter int FLAG_BITS   = 3,
  parameter int SW_BITS     = 4,
  parameter logic [ADDR_W-1:0] VEC_BOOT = '0,
  parameter logic [ADDR_W-1:0] VEC_LOW  = 24'h000002,
  parameter logic [ADDR_W-1:0] VEC_HIGH = 24'h000004
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [1:0]                   irqN,
  input  logic                         flagWe,
  input  logic [FLAG_BITS-1:0]         flagIn,
  input  logic                         psrWe,
  input  logic [FLAG_BITS+SW_BITS:0]   psrIn,
  input  ctrlStrobe_t                  strobe,
  output logic [1:0]                   irqActive,
  output logic                         intEnable,
  output logic                         swAny,
  output logic [FLAG_BITS+SW_BITS:0]   psrQ,
  output logic                         pcLoad,
  output logic                         takeIrq,
  output logic [ADDR_W-1:0]            pcVector
);

  localparam int PSR_W  = FLAG_BITS + SW_BITS + 1;
  localparam int IE_POS = FLAG_BITS;
  localparam int SW_LO  = FLAG_BITS + 1;
  localparam int SW_HI  = PSR_W - 1;

  // Synchroniser chain, one stage per generate step
  logic [1:0] syncQ [SYNC_STAGES];

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge clk) begin
          if (rst) syncQ[g] <= 2'b11;
          else     syncQ[g] <= irqN;
        end
      end else begin : gRest
        always_ff @(posedge clk) begin
          if (rst) syncQ[g] <= 2'b11;
          else     syncQ[g] <= syncQ[g-1];
        end
      end
    end
  endgenerate

  assign irqActive = ~syncQ[SYNC_STAGES-1];

  // Status register
  logic [PSR_W-1:0] psrNext;

  always_comb begin
    psrNext = psrQ;
    if (flagWe)      psrNext[FLAG_BITS-1:0] = flagIn;
    if (psrWe)       psrNext = psrIn;
    if (strobe.take) psrNext[IE_POS] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) psrQ <= '0;
    else     psrQ <= psrNext;
  end

  assign intEnable = psrQ[IE_POS];
  assign swAny     = |psrQ[SW_HI:SW_LO];

  // Registered program-counter interface
  always_ff @(posedge clk) begin
    if (rst) begin
      pcLoad   <= 1'b0;
      takeIrq  <= 1'b0;
      pcVector <= '0;
    end else begin
      pcLoad  <= strobe.load;
      takeIrq <= strobe.take;
      if (strobe.load) begin
        case (strobe.sel)
          VSEL_HIGH: pcVector <= VEC_HIGH;
          VSEL_LOW:  pcVector <= VEC_LOW;
          default:   pcVector <= VEC_BOOT;
        endcase
      end
    end
  end

  // R7: enable is low once a take has been issued
  a_r7_enable_dropped: assert property (@(posedge clk) disable iff (rst)
    takeIrq |-> !psrQ[IE_POS]);

  // R10: a take requires the enable bit to have been set
  a_r10_needs_enable: assert property (@(posedge clk) disable iff (rst)
    takeIrq |-> $past(psrQ[IE_POS]));

  // R13: single-cycle take pulse
  a_r13_single_pulse: assert property (@(posedge clk) disable iff (rst)
    takeIrq |=> !takeIrq);

  // R8: software bits survive a take with no concurrent write
  a_r8_sw_held: assert property (@(posedge clk) disable iff (rst)
    (takeIrq && !$past(psrWe)) |-> (psrQ[SW_HI:SW_LO] == $past(psrQ[SW_HI:SW_LO])));

  // R5: the high-priority line wins the vector
  a_r5_high_wins: assert property (@(posedge clk) disable iff (rst)
    (takeIrq && $past(irqActive[1])) |-> (pcVector == VEC_HIGH));

  // R4: without the high line the low vector is used
  a_r4_low_vector: assert property (@(posedge clk) disable iff (rst)
    (takeIrq && !$past(irqActive[1])) |-> (pcVector == VEC_LOW));

  // R1: a load that is not an interrupt is the boot load
  a_r1_boot_vector: assert property (@(posedge clk) disable iff (rst)
    (pcLoad && !takeIrq) |-> (pcVector == VEC_BOOT));

  // R11: lone flag write lands in the flag field
  a_r11_flag_write: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && flagWe && !psrWe) |-> (psrQ[FLAG_BITS-1:0] == $past(flagIn)));

endmodule

// File: rtl/intEntrySeq.sv
module intEntrySeq
  import intEntryPkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int SYNC_STAGES = 2,
  parameter int FLAG_BITS   = 3,
  parameter int SW_BITS     = 4,
  parameter logic [ADDR_W-1:0] VEC_BOOT = '0,
  parameter logic [ADDR_W-1:0] VEC_LOW  = 24'h000002,
  parameter logic [ADDR_W-1:0] VEC_HIGH = 24'h000004
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [1:0]                   irqN,
  input  logic                         instrDone,
  input  logic                         flagWe,
  input  logic [FLAG_BITS-1:0]         flagIn,
  input  logic                         psrWe,
  input  logic [FLAG_BITS+SW_BITS:0]   psrIn,
  output logic [FLAG_BITS+SW_BITS:0]   psrOut,
  output logic                         pcLoad,
  output logic                         takeIrq,
  output logic [ADDR_W-1:0]            pcVector
);

  ctrlStrobe_t strobe;
  logic [1:0]  irqActive;
  logic        intEnable;
  logic        swAny;

  intEntryCtrl uCtrl (
    .clk       (clk),
    .rst       (rst),
    .instrDone (instrDone),
    .irqActive (irqActive),
    .intEnable (intEnable),
    .swAny     (swAny),
    .strobe    (strobe)
  );

  intEntryPath #(
    .ADDR_W      (ADDR_W),
    .SYNC_STAGES (SYNC_STAGES),
    .FLAG_BITS   (FLAG_BITS),
    .SW_BITS     (SW_BITS),
    .VEC_BOOT    (VEC_BOOT),
    .VEC_LOW     (VEC_LOW),
    .VEC_HIGH    (VEC_HIGH)
  ) uPath (
    .clk       (clk),
    .rst       (rst),
    .irqN      (irqN),
    .flagWe    (flagWe),
    .flagIn    (flagIn),
    .psrWe     (psrWe),
    .psrIn     (psrIn),
    .strobe    (strobe),
    .irqActive (irqActive),
    .intEnable (intEnable),
    .swAny     (swAny),
    .psrQ      (psrOut),
    .pcLoad    (pcLoad),
    .takeIrq   (takeIrq),
    .pcVector  (pcVector)
  );

  // R3: a take pulse follows an edge that saw an instruction boundary
  a_r3_at_boundary: assert property (@(posedge clk) disable iff (rst)
    takeIrq |-> $past(instrDone));

endmodule

// File: tb/intEntrySeq_test.sv
`timescale 1ns/1ps
module intEntrySeq_test;

  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  irqN;
  logic        instrDone;
  logic        flagWe;
  logic [2:0]  flagIn;
  logic        psrWe;
  logic [7:0]  psrIn;
  logic [7:0]  psrOut;
  logic        pcLoad;
  logic        takeIrq;
  logic [23:0] pcVector;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  intEntrySeq uut (
    .clk(clk), .rst(rst), .irqN(irqN), .instrDone(instrDone),
    .flagWe(flagWe), .flagIn(flagIn), .psrWe(psrWe), .psrIn(psrIn),
    .psrOut(psrOut), .pcLoad(pcLoad), .takeIrq(takeIrq), .pcVector(pcVector)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setPsr(input logic [7:0] v);
    psrWe = 1'b1; psrIn = v;
    step();
    psrWe = 1'b0;
  endtask

  task automatic releaseLines();
    irqN = 2'b11; instrDone = 1'b0;
    repeat (3) step();
  endtask

  task automatic tReset();
    rst = 1'b1; irqN = 2'b11; instrDone = 1'b0;
    flagWe = 1'b0; flagIn = '0; psrWe = 1'b0; psrIn = '0;
    repeat (3) step();
    check("R2 psr in reset", psrOut, 8'h00);
    check("R2 pcLoad in reset", pcLoad, 1'b0);
    check("R2 takeIrq in reset", takeIrq, 1'b0);
    rst = 1'b0;
    step();
    check("R1 boot load", pcLoad, 1'b1);
    check("R1 boot vector", pcVector, 24'h000000);
    check("R1 boot not irq", takeIrq, 1'b0);
    step();
    check("R1 boot pulse ends", pcLoad, 1'b0);
  endtask

  task automatic tDisabled();
    irqN = 2'b00; instrDone = 1'b1;
    for (int i = 0; i < 5; i++) begin
      step();
      check("R10 no load while disabled", pcLoad, 1'b0);
    end
    setPsr(8'h10);
    step();
    check("R10 sw ignored while disabled", takeIrq, 1'b0);
    check("R10 psr untouched", psrOut, 8'h10);
    setPsr(8'h00);
    releaseLines();
  endtask

  task automatic tLowLine();
    setPsr(8'h08);
    irqN = 2'b10; instrDone = 1'b0;
    for (int i = 0; i < 4; i++) begin
      step();
      check("R3 no take without boundary", takeIrq, 1'b0);
    end
    instrDone = 1'b1;
    step();
    check("R3 take after boundary", takeIrq, 1'b1);
    check("R3 load with take", pcLoad, 1'b1);
    check("R4 low line vector", pcVector, 24'h000002);
    check("R7 enable cleared", psrOut, 8'h00);
    step();
    check("R13 take ends", takeIrq, 1'b0);
    for (int i = 0; i < 3; i++) begin
      step();
      check("R7 blocked while pending", pcLoad, 1'b0);
    end
    releaseLines();
  endtask

  task automatic tLatency();
    setPsr(8'h08);
    instrDone = 1'b1; irqN = 2'b01;
    step();
    check("R9 not after edge 1", pcLoad, 1'b0);
    step();
    check("R9 not after edge 2", pcLoad, 1'b0);
    step();
    check("R9 load after edge 3", pcLoad, 1'b1);
    check("R4 high line vector", pcVector, 24'h000004);
    releaseLines();
  endtask

  task automatic tBothLow();
    setPsr(8'h08);
    irqN = 2'b00; instrDone = 1'b0;
    repeat (3) step();
    instrDone = 1'b1;
    step();
    check("R5 take both low", takeIrq, 1'b1);
    check("R5 high wins", pcVector, 24'h000004);
    releaseLines();
  endtask

  task automatic tSoftware();
    setPsr(8'h18);
    instrDone = 1'b1;
    step();
    check("R6 sw take", takeIrq, 1'b1);
    check("R6 sw vector", pcVector, 24'h000002);
    check("R8 sw bits kept", psrOut, 8'h10);
    instrDone = 1'b0;
    step();
    check("R8 sw bits still kept", psrOut, 8'h10);
    setPsr(8'h18);
    irqN = 2'b01;
    repeat (3) step();
    instrDone = 1'b1;
    step();
    check("R6 high line beats sw", pcVector, 24'h000004);
    releaseLines();
    setPsr(8'h00);
    check("R8 sw cleared by write", psrOut, 8'h00);
  endtask

  task automatic tWriteOrder();
    setPsr(8'h08);
    instrDone = 1'b1; psrWe = 1'b1; psrIn = 8'h18;
    step();
    check("R12 old value decides", takeIrq, 1'b0);
    check("R12 write stored", psrOut, 8'h18);
    psrWe = 1'b0;
    step();
    check("R12 taken next boundary", takeIrq, 1'b1);
    check("R12 vector", pcVector, 24'h000002);
    check("R12 enable cleared", psrOut, 8'h10);
    instrDone = 1'b0;
    setPsr(8'h18);
    instrDone = 1'b1; psrWe = 1'b1; psrIn = 8'h1F;
    step();
    check("R12 collision take", takeIrq, 1'b1);
    check("R12 collision psr", psrOut, 8'h17);
    psrWe = 1'b0; instrDone = 1'b0;
    setPsr(8'h00);
  endtask

  task automatic tFlags();
    flagWe = 1'b1; flagIn = 3'b101;
    step();
    check("R11 flag write", psrOut, 8'h05);
    flagIn = 3'b111; psrWe = 1'b1; psrIn = 8'h40;
    step();
    check("R11 psr write wins", psrOut, 8'h40);
    flagWe = 1'b0; psrWe = 1'b0;
    rst = 1'b1;
    step();
    check("R2 reset again psr", psrOut, 8'h00);
    check("R2 reset again load", pcLoad, 1'b0);
    rst = 1'b0;
    step();
    check("R1 reboot load", pcLoad, 1'b1);
    check("R1 reboot vector", pcVector, 24'h000000);
  endtask

  initial begin
    tReset();
    tDisabled();
    tLowLine();
    tLatency();
    tBothLow();
    tSoftware();
    tWriteOrder();
    tFlags();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule